// File: doc/BRIEF.md
# Double-Buffered PWM Channel with Fine Edge Delay

This block drives one PWM pin from a loop-rate period counter. On every loop tick the counter advances and wraps at a programmable period. The pin goes high at the wrap and low when the counter reaches the active compare value. Software never writes the active compare directly. It writes a shadow register at any moment, and the shadow is copied into the active register only at the next compare event. A compare value therefore changes only at a clean point in the waveform, as a double-buffered hardware compare would.

A fine-delay extension moves the falling edge later within the loop period. The delay is counted in high-resolution clock enables, which run at a multiple (2 to 128) of the loop tick. Each loop period accepts at most one fine-delay request. A further request in the same period is dropped and sets a sticky error flag.

The edge logic is a three-state machine. ST_LOW holds the pin low and moves to ST_HIGH at a wrap when the effective compare is non-zero. ST_HIGH returns to ST_LOW at a wrap whose effective compare is zero. It also goes to ST_LOW on a mid-period compare match when the delay is zero, or to ST_HR_WAIT when the delay is non-zero. ST_HR_WAIT counts high-resolution enables down and drops to ST_LOW when the count expires. If a loop tick arrives first, the wait is cut short: it moves to ST_HIGH at a wrap with a non-zero compare, and to ST_LOW otherwise.

Top module: `pwm_hr_dbuf`

## Requirements
- R1: After reset, pwm_out is 0, shadow_pending is 0 and hr_err is 0.
- R2: The counter advances once per loop_tick, from 0 up to period-1, then wraps to 0. pwm_out rises with the wrap tick and, with a zero fine delay, falls with the tick that brings the counter to the active compare value c. With a loop tick every M cycles it is high for c*M cycles.
- R3: A write to address 0 stores the shadow compare and sets shadow_pending. The active compare, and so the pin waveform, stays unchanged until the next compare event.
- R4: At a compare event with a value pending, the shadow is copied to the active compare and shadow_pending clears. A mid-period match takes the new value from the following wrap. A match at the wrap applies it to the period that wrap starts.
- R5: A shadow write made after the current period's match waits for the match of the next period, so one more full period runs with the old value.
- R6: An active compare of 0 keeps pwm_out low for the whole period. For this value the wrap itself is the compare event.
- R7: An active compare at or above the period keeps pwm_out high for the whole period. For this value the wrap also serves as the compare event for a pending transfer.
- R8: A write to address 2 sets the fine delay d (low bits of wr_data). The falling edge then comes d hr_en pulses after the matching tick instead of with it.
- R9: Only the first address-2 write in a loop period is accepted. A later one in the same period leaves the delay unchanged and sets hr_err, which stays set until reset.
- R10: A write to address 1 sets the period. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (high-resolution rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_tick | input | 1 | One-cycle pulse per loop-resolution step |
| hr_en | input | 1 | High-resolution step enable |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | 0 shadow compare, 1 period, 2 fine delay, 3 unused |
| wr_data | input | CNT_W | Host write data |
| pwm_out | output | 1 | PWM pin |
| shadow_pending | output | 1 | Shadow compare awaiting transfer |
| hr_err | output | 1 | Sticky rejected fine-delay request |

## Verification
The bench builds the block with an 8-bit counter and a fine-delay range of 8 (a 3-bit delay field). It programs a period of 6 and sends a loop tick every 4 cycles with hr_en high on every cycle, so the multiplier is 4. A whole period is then only 24 cycles. That makes it cheap to play many full periods back to back and compare the pin on every cycle: delays up to 3, shadow writes before and after the match, and both clamp values (0 and a compare above the period), including transfers into and out of them.

// File: rtl/pwm_hr_pkg.sv
package pwm_hr_pkg;

    typedef enum logic [1:0] {
        ST_LOW     = 2'd0,
        ST_HIGH    = 2'd1,
        ST_HR_WAIT = 2'd2
    } edge_state_t;

    typedef enum logic [1:0] {
        ADDR_SHADOW = 2'd0,
        ADDR_PERIOD = 2'd1,
        ADDR_HRDLY  = 2'd2,
        ADDR_SPARE  = 2'd3
    } host_addr_t;

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int CNT_W      = 8,
    parameter int RST_PERIOD = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_tick,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_din,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] period,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    always_comb begin
        at_end   = (period <= CNT_W'(1)) || (cnt_q >= period - CNT_W'(1));
        cnt_next = at_end ? '0 : cnt_q + CNT_W'(1);
        wrap     = loop_tick && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            period <= CNT_W'(RST_PERIOD);
        end else begin
            if (loop_tick) cnt_q  <= cnt_next;
            if (period_wr) period <= period_din;
        end
    end
endmodule

// File: rtl/pwm_cmp_buffer.sv
module pwm_cmp_buffer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [CNT_W-1:0] period,
    input  logic             sh_wr,
    input  logic [CNT_W-1:0] sh_din,
    output logic             cmp_eff_nz,
    output logic             fall_hit,
    output logic             pending
);
    logic [CNT_W-1:0] sh_q;
    logic [CNT_W-1:0] act_q;
    logic             hit;
    logic             xfer;
    logic [CNT_W-1:0] cmp_eff;

    always_comb begin
        hit        = loop_tick && ((cnt_next == act_q) || (wrap && (act_q >= period)));
        xfer       = hit && pending;
        cmp_eff    = xfer ? sh_q : act_q;
        cmp_eff_nz = (cmp_eff != '0);
        fall_hit   = loop_tick && !wrap && (cnt_next == act_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            act_q   <= '0;
            pending <= 1'b0;
        end else begin
            if (sh_wr) sh_q  <= sh_din;
            if (xfer)  act_q <= sh_q;
            if (sh_wr)     pending <= 1'b1;
            else if (xfer) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_hr_gate.sv
module pwm_hr_gate #(
    parameter int HR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            loop_tick,
    input  logic            req,
    input  logic [HR_W-1:0] req_dly,
    output logic [HR_W-1:0] dly,
    output logic            err
);
    logic used_q;
    logic accept;

    always_comb accept = req && (!used_q || loop_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= 1'b0;
            dly    <= '0;
            err    <= 1'b0;
        end else begin
            if (accept) dly <= req_dly;
            if (accept)         used_q <= 1'b1;
            else if (loop_tick) used_q <= 1'b0;
            if (req && !accept) err <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm_hr_edge_fsm.sv
module pwm_hr_edge_fsm
    import pwm_hr_pkg::*;
#(
    parameter int HR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            loop_tick,
    input  logic            hr_en,
    input  logic            wrap,
    input  logic            cmp_eff_nz,
    input  logic            fall_hit,
    input  logic [HR_W-1:0] hr_dly,
    output logic            pin
);
    edge_state_t     state_q, state_nxt;
    logic [HR_W-1:0] hr_q, hr_nxt;

    always_comb begin
        state_nxt = state_q;
        hr_nxt    = hr_q;
        unique case (state_q)
            ST_LOW: begin
                if (wrap && cmp_eff_nz) state_nxt = ST_HIGH;
            end
            ST_HIGH: begin
                if (wrap) begin
                    if (!cmp_eff_nz) state_nxt = ST_LOW;
                end else if (fall_hit) begin
                    if (hr_dly == '0) begin
                        state_nxt = ST_LOW;
                    end else begin
                        state_nxt = ST_HR_WAIT;
                        hr_nxt    = hr_dly;
                    end
                end
            end
            ST_HR_WAIT: begin
                if (loop_tick) begin
                    state_nxt = (wrap && cmp_eff_nz) ? ST_HIGH : ST_LOW;
                end else if (hr_en) begin
                    hr_nxt = hr_q - HR_W'(1);
                    if (hr_q <= HR_W'(1)) state_nxt = ST_LOW;
                end
            end
            default: state_nxt = ST_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
            hr_q    <= '0;
        end else begin
            state_q <= state_nxt;
            hr_q    <= hr_nxt;
        end
    end

    // registered pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= (state_nxt != ST_LOW);
    end
endmodule

// File: rtl/pwm_hr_dbuf.sv
module pwm_hr_dbuf
    import pwm_hr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int HR_MAX_MULT = 128,
    parameter int RST_PERIOD  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_tick,
    input  logic             hr_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             shadow_pending,
    output logic             hr_err
);
    localparam int HR_W = $clog2(HR_MAX_MULT);

    logic             sh_wr, per_wr, hr_req;
    logic [CNT_W-1:0] cnt_next, period;
    logic             wrap, cmp_eff_nz, fall_hit;
    logic [HR_W-1:0]  hr_dly;

    always_comb begin
        sh_wr  = wr_en && (wr_addr == ADDR_SHADOW);
        per_wr = wr_en && (wr_addr == ADDR_PERIOD);
        hr_req = wr_en && (wr_addr == ADDR_HRDLY);
    end

    pwm_period_ctr #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) i_ctr (
        .clk(clk), .rst_n(rst_n), .loop_tick(loop_tick),
        .period_wr(per_wr), .period_din(wr_data),
        .cnt_next(cnt_next), .period(period), .wrap(wrap)
    );

    pwm_cmp_buffer #(.CNT_W(CNT_W)) i_cmp (
        .clk(clk), .rst_n(rst_n), .loop_tick(loop_tick), .wrap(wrap),
        .cnt_next(cnt_next), .period(period),
        .sh_wr(sh_wr), .sh_din(wr_data),
        .cmp_eff_nz(cmp_eff_nz), .fall_hit(fall_hit), .pending(shadow_pending)
    );

    pwm_hr_gate #(.HR_W(HR_W)) i_gate (
        .clk(clk), .rst_n(rst_n), .loop_tick(loop_tick),
        .req(hr_req), .req_dly(wr_data[HR_W-1:0]),
        .dly(hr_dly), .err(hr_err)
    );

    pwm_hr_edge_fsm #(.HR_W(HR_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .loop_tick(loop_tick), .hr_en(hr_en),
        .wrap(wrap), .cmp_eff_nz(cmp_eff_nz), .fall_hit(fall_hit),
        .hr_dly(hr_dly), .pin(pwm_out)
    );
endmodule

// File: rtl/pwm_hr_dbuf_chk.sv
module pwm_hr_dbuf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_tick,
    input logic       hr_en,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       pwm_out,
    input logic       shadow_pending,
    input logic       hr_err
);
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (!pwm_out && !shadow_pending && !hr_err));

    assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(loop_tick));

    assert_pending_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shadow_pending) |-> $past(wr_en && (wr_addr == 2'd0)));

    assert_xfer_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shadow_pending) |-> $past(loop_tick));

    assert_fall_on_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> $past(loop_tick || hr_en));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hr_err |=> hr_err);

    assert_err_from_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hr_err) |-> $past(wr_en && (wr_addr == 2'd2)));
endmodule

bind pwm_hr_dbuf pwm_hr_dbuf_chk i_chk (
    .clk(clk), .rst_n(rst_n), .loop_tick(loop_tick), .hr_en(hr_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .pwm_out(pwm_out),
    .shadow_pending(shadow_pending), .hr_err(hr_err)
);

// File: tb/test_pwm_hr_dbuf.sv
module test_pwm_hr_dbuf;
    localparam int P = 6;
    localparam int M = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loop_tick = 1'b0;
    logic       hr_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out, shadow_pending, hr_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  pin;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    pwm_hr_dbuf #(.CNT_W(8), .HR_MAX_MULT(8), .RST_PERIOD(16)) i_pwm_hr_dbuf (
        .clk(clk), .rst_n(rst_n), .loop_tick(loop_tick), .hr_en(hr_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .shadow_pending(shadow_pending), .hr_err(hr_err)
    );

    task automatic check(input string tag, input logic act, input logic expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, expv, $time);
        end
    endtask

    // monitor: pops one expected pin value per cycle while a period plays
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, pwm_out, e.pin);
        end
    end

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: one full loop period starting at the wrap tick
    task automatic play(input int c, input int d, input string tag,
                        input int wat, input logic [1:0] wa, input logic [7:0] wd);
        for (int j = 0; j < P * M; j++) begin
            exp_t e;
            @(negedge clk);
            loop_tick = (j % M == 0);
            wr_en     = (j == wat);
            wr_addr   = wa;
            wr_data   = wd;
            e.tag = tag;
            if (c == 0)      e.pin = 1'b0;
            else if (c >= P) e.pin = 1'b1;
            else             e.pin = (j < c * M + d);
            exp_q.push_back(e);
        end
        @(negedge clk);
        loop_tick = 1'b0;
        wr_en     = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pin", pwm_out, 1'b0);
        check("R1 pending", shadow_pending, 1'b0);
        check("R1 err", hr_err, 1'b0);
        rst_n = 1'b1;

        // R10 period write, then bring the counter to period-1
        host_wr(2'd1, 8'(P));
        for (int k = 0; k < P - 1; k++) begin
            @(negedge clk); loop_tick = 1'b1;
            @(negedge clk); loop_tick = 1'b0;
        end
        check("R2 low before first wrap", pwm_out, 1'b0);

        // R3 / R4: shadow write, transfer at wrap match of compare 0
        host_wr(2'd0, 8'd3);
        check("R3 pending set", shadow_pending, 1'b1);
        play(3, 0, "R4 first transfer", -1, 2'd0, 8'd0);
        check("R4 pending cleared", shadow_pending, 1'b0);

        // R3: write before match keeps old waveform this period
        play(3, 0, "R3 old value held", 2, 2'd0, 8'd5);
        check("R4 pending cleared at match", shadow_pending, 1'b0);

        // R5: write after match waits a full extra period
        play(5, 0, "R2 compare 5", 22, 2'd0, 8'd2);
        check("R5 still pending", shadow_pending, 1'b1);
        play(5, 0, "R5 extra period", -1, 2'd0, 8'd0);
        check("R5 pending cleared", shadow_pending, 1'b0);
        play(2, 0, "R4 new value", -1, 2'd0, 8'd0);

        // R8 fine delay
        host_wr(2'd2, 8'd3);
        check("R9 no err on single", hr_err, 1'b0);
        play(2, 3, "R8 delay 3", -1, 2'd0, 8'd0);

        // R9 second request in the same period is dropped
        host_wr(2'd2, 8'd1);
        host_wr(2'd2, 8'd2);
        check("R9 err set", hr_err, 1'b1);
        play(2, 1, "R9 delay 1 kept", -1, 2'd0, 8'd0);
        check("R9 err sticky", hr_err, 1'b1);

        // R7 compare above period, R6 compare 0
        host_wr(2'd0, 8'd9);
        play(2, 1, "R4 match before clamp", -1, 2'd0, 8'd0);
        play(9, 0, "R7 full high", -1, 2'd0, 8'd0);
        host_wr(2'd0, 8'd0);
        check("R7 high in gap", pwm_out, 1'b1);
        play(0, 0, "R7 wrap transfer to 0", -1, 2'd0, 8'd0);
        check("R7 pending cleared at wrap", shadow_pending, 1'b0);
        play(0, 0, "R6 full low", -1, 2'd0, 8'd0);
        host_wr(2'd0, 8'd4);
        play(4, 1, "R6 wrap transfer from 0", -1, 2'd0, 8'd0);

        // R10 spare address has no effect
        host_wr(2'd3, 8'd1);
        check("R10 spare no pending", shadow_pending, 1'b0);
        play(4, 1, "R10 spare no effect", -1, 2'd0, 8'd0);

        repeat (2) @(negedge clk);
        report();
    end
endmodule